// File: doc/BRIEF.md
# CAN Controller Mode Sequencer

This block is the control state machine that sits next to a CAN protocol engine and decides when that engine may be halted for debugging or put into a low-power off state. Software supplies a halt request, a freeze enable and an off request, and a debugger can supply its own halt. The sequencer watches the protocol engine's state flags, its busy flag and the sampled receive line. It moves the engine into or out of the quiet modes only at bus-safe points, and it drives the status, clock-gate, pin-control and register-access permission outputs.

On any exit from a quiet mode, and after reset, the sequencer holds a not-ready status. It keeps that status until it has seen a run of consecutive recessive bits, so that the engine rejoins a bus that is already in progress without disturbing it. Freeze entry is allowed at more protocol states than off entry. Off entry during traffic can complete at the last intermission bit, but only when that bit is sampled recessive.

Top module: `can_mode_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after release until the first resync completes, `freeze_ack`=0, `sleep_ack`=0, `not_ready`=1, `errcnt_wr_en`=0, `rx_ignore`=0, `tx_force_rec`=0, and `presc_run`, both clock enables and all three access enables are 1.
- R2: A freeze request counts only when `freeze_en`=1, `off_req`=0, `stop_req`=0 and at least one of `halt_req` or `dbg_halt` is 1. Without such a request the outputs stay unchanged even when the engine is idle.
- R3: A counted freeze request enters the frozen state only after one of `pe_idle`, `pe_intermission`, `pe_err_passive` or `pe_bus_off` has been seen since the request, and only in a cycle with `engine_busy`=0. A safe point seen while busy is remembered. Entry takes effect one clock after the enabling cycle.
- R4: While frozen: `freeze_ack`=1, `not_ready`=1, `presc_run`=0, `rx_ignore`=1, `tx_force_rec`=1, `errcnt_wr_en`=1, and both clock enables and all access enables are 1.
- R5: When the counted freeze request goes away, the next clock leaves the frozen state. `freeze_ack` drops, the prescaler runs and `not_ready` stays 1 during resync.
- R6: `not_ready` clears only after RESYNC_BITS (11) consecutive `bit_tick` samples with `rx_bit`=1 (recessive). A sample with `rx_bit`=0 restarts the count. `not_ready` falls at the second clock edge that follows the final tick.
- R7: Raising `off_req` while frozen enters the off state at the next clock, with `freeze_ack`=0 and `sleep_ack`=1.
- R8: Raising `off_req` outside freeze waits for `pe_idle` or `pe_bus_off`, or for a `bit_tick` with `pe_intermission`=1, `ifs_bit_idx`=3 and `rx_bit`=1, and then for `engine_busy`=0. A dominant third intermission bit or an earlier intermission bit does not qualify.
- R9: While off: `sleep_ack`=1, `not_ready`=1, `rx_ignore`=1, `tx_force_rec`=1, and `presc_run`, both clock enables, `errcnt_wr_en`, `errcnt_acc_en`, `timer_acc_en` and `mbuf_acc_en` are 0.
- R10: Dropping `off_req` while off enters resync at the next clock: the clocks are ungated, `sleep_ack`=0 and `not_ready`=1.
- R11: Withdrawing a pending freeze or off request before entry returns to the previous operation without a resync. `not_ready` keeps its value, and a later safe point causes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_req | input | 1 | Software halt request |
| dbg_halt | input | 1 | Debugger has stopped the core |
| freeze_en | input | 1 | Freeze permitted |
| off_req | input | 1 | Module-off request |
| stop_req | input | 1 | System stop low-power mode active |
| pe_idle | input | 1 | Protocol engine idle |
| pe_intermission | input | 1 | Protocol engine in intermission |
| pe_err_passive | input | 1 | Protocol engine error-passive |
| pe_bus_off | input | 1 | Protocol engine bus-off |
| ifs_bit_idx | input | IBIT_W | Index of current intermission bit (1-based) |
| bit_tick | input | 1 | One-cycle strobe at each bit sample point |
| rx_bit | input | 1 | Sampled receive line (1 = recessive) |
| engine_busy | input | 1 | Arbitration, matching or buffer moves in progress |
| freeze_ack | output | 1 | Frozen acknowledge |
| sleep_ack | output | 1 | Off-mode acknowledge |
| not_ready | output | 1 | Engine not participating on the bus |
| presc_run | output | 1 | Bit-time prescaler enable |
| pe_clk_en | output | 1 | Protocol engine clock enable |
| bm_clk_en | output | 1 | Buffer manager clock enable |
| rx_ignore | output | 1 | Ignore receive input |
| tx_force_rec | output | 1 | Force transmit recessive |
| errcnt_wr_en | output | 1 | Error counter register writable |
| errcnt_acc_en | output | 1 | Error counter register accessible |
| timer_acc_en | output | 1 | Free-running timer accessible |
| mbuf_acc_en | output | 1 | Message buffers accessible |

## Verification
The bench builds the sequencer with its default parameters: RESYNC_BITS of 11 and a last intermission bit of 3 on a 2-bit index. With these values the exact resync length can be checked: ten recessive bits are not enough, a dominant bit in the middle of the run restarts the count, and the eleventh bit releases `not_ready`. The 2-bit index also lets the bench present the second intermission bit, and a dominant third bit, as points that must not count, next to the recessive third bit that does count.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
   typedef enum logic [2:0] {
      ST_RESYNC   = 3'd0,
      ST_RUN      = 3'd1,
      ST_FRZ_WAIT = 3'd2,
      ST_FROZEN   = 3'd3,
      ST_OFF_WAIT = 3'd4,
      ST_OFF      = 3'd5
   } mode_st_t;

   typedef struct packed {
      logic freeze_ack;
      logic sleep_ack;
      logic presc_run;
      logic clk_en;
      logic pins_quiet;
      logic errcnt_wr;
      logic restricted_acc;
   } mode_dec_t;
endpackage

// File: rtl/can_resync_ctr.sv
module can_resync_ctr #(
   parameter int unsigned RUN_LEN   = 11,
   parameter bit          REC_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   input  logic rx,
   output logic done
);
   localparam int unsigned CW = $clog2(RUN_LEN + 1);
   localparam logic [CW-1:0] LIMIT = CW'(RUN_LEN);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt_q <= '0;
      end else if (tick) begin
         if (rx != REC_LEVEL)
            cnt_q <= '0;
         else if (cnt_q != LIMIT)
            cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done = (cnt_q == LIMIT);
endmodule

// File: rtl/can_entry_gate.sv
module can_entry_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic point,
   input  logic busy,
   output logic ready
);
   logic seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !arm)
         seen_q <= 1'b0;
      else if (point)
         seen_q <= 1'b1;
   end

   assign ready = arm && (seen_q || point) && !busy;
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
   import can_mode_pkg::*;
#(
   parameter int unsigned RESYNC_BITS = 11,
   parameter int unsigned IBIT_W      = 2,
   parameter int unsigned IFS_LAST    = 3,
   parameter bit          REC_LEVEL   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              halt_req,
   input  logic              dbg_halt,
   input  logic              freeze_en,
   input  logic              off_req,
   input  logic              stop_req,
   input  logic              pe_idle,
   input  logic              pe_intermission,
   input  logic              pe_err_passive,
   input  logic              pe_bus_off,
   input  logic [IBIT_W-1:0] ifs_bit_idx,
   input  logic              bit_tick,
   input  logic              rx_bit,
   input  logic              engine_busy,
   output logic              freeze_ack,
   output logic              sleep_ack,
   output logic              not_ready,
   output logic              presc_run,
   output logic              pe_clk_en,
   output logic              bm_clk_en,
   output logic              rx_ignore,
   output logic              tx_force_rec,
   output logic              errcnt_wr_en,
   output logic              errcnt_acc_en,
   output logic              timer_acc_en,
   output logic              mbuf_acc_en
);
   localparam logic [IBIT_W-1:0] LAST_IDX = IBIT_W'(IFS_LAST);

   generate
      if (RESYNC_BITS < 1) begin : g_bad_run
         $error("RESYNC_BITS must be at least 1");
      end
      if (IFS_LAST >= (1 << IBIT_W)) begin : g_bad_idx
         $error("IFS_LAST does not fit in IBIT_W");
      end
   endgenerate

   mode_st_t  st_q, st_d;
   logic      nr_q, nr_d;
   mode_dec_t dec;

   logic frz_req, frz_pt, off_pt, frz_ready, off_ready, run_done;

   assign frz_req = freeze_en && (halt_req || dbg_halt) && !off_req && !stop_req;
   assign frz_pt  = pe_idle || pe_intermission || pe_err_passive || pe_bus_off;
   assign off_pt  = pe_idle || pe_bus_off ||
                    (pe_intermission && bit_tick && (ifs_bit_idx == LAST_IDX) &&
                     (rx_bit == REC_LEVEL));

   can_entry_gate u_frz_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .arm   (st_q == ST_FRZ_WAIT),
      .point (frz_pt),
      .busy  (engine_busy),
      .ready (frz_ready)
   );

   can_entry_gate u_off_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .arm   (st_q == ST_OFF_WAIT),
      .point (off_pt),
      .busy  (engine_busy),
      .ready (off_ready)
   );

   can_resync_ctr #(
      .RUN_LEN   (RESYNC_BITS),
      .REC_LEVEL (REC_LEVEL)
   ) u_resync (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (st_q != ST_RESYNC),
      .tick  (bit_tick),
      .rx    (rx_bit),
      .done  (run_done)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_RESYNC: begin
            if (off_req)       st_d = ST_OFF_WAIT;
            else if (frz_req)  st_d = ST_FRZ_WAIT;
            else if (run_done) st_d = ST_RUN;
         end
         ST_RUN: begin
            if (off_req)       st_d = ST_OFF_WAIT;
            else if (frz_req)  st_d = ST_FRZ_WAIT;
         end
         ST_FRZ_WAIT: begin
            if (off_req)        st_d = ST_OFF_WAIT;
            else if (!frz_req)  st_d = nr_q ? ST_RESYNC : ST_RUN;
            else if (frz_ready) st_d = ST_FROZEN;
         end
         ST_FROZEN: begin
            if (off_req)       st_d = ST_OFF;
            else if (!frz_req) st_d = ST_RESYNC;
         end
         ST_OFF_WAIT: begin
            if (!off_req)       st_d = nr_q ? ST_RESYNC : ST_RUN;
            else if (off_ready) st_d = ST_OFF;
         end
         ST_OFF: begin
            if (!off_req)      st_d = ST_RESYNC;
         end
         default:              st_d = ST_RESYNC;
      endcase
   end

   always_comb begin
      nr_d = nr_q;
      if (st_d == ST_FROZEN || st_d == ST_OFF) nr_d = 1'b1;
      else if (st_d == ST_RUN)                 nr_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= ST_RESYNC;
         nr_q <= 1'b1;
      end else begin
         st_q <= st_d;
         nr_q <= nr_d;
      end
   end

   always_comb begin
      dec = '{freeze_ack: 1'b0, sleep_ack: 1'b0, presc_run: 1'b1, clk_en: 1'b1,
              pins_quiet: 1'b0, errcnt_wr: 1'b0, restricted_acc: 1'b1};
      if (st_q == ST_FROZEN) begin
         dec.freeze_ack = 1'b1;
         dec.presc_run  = 1'b0;
         dec.pins_quiet = 1'b1;
         dec.errcnt_wr  = 1'b1;
      end else if (st_q == ST_OFF) begin
         dec.sleep_ack      = 1'b1;
         dec.presc_run      = 1'b0;
         dec.clk_en         = 1'b0;
         dec.pins_quiet     = 1'b1;
         dec.restricted_acc = 1'b0;
      end
   end

   assign freeze_ack    = dec.freeze_ack;
   assign sleep_ack     = dec.sleep_ack;
   assign not_ready     = nr_q;
   assign presc_run     = dec.presc_run;
   assign pe_clk_en     = dec.clk_en;
   assign bm_clk_en     = dec.clk_en;
   assign rx_ignore     = dec.pins_quiet;
   assign tx_force_rec  = dec.pins_quiet;
   assign errcnt_wr_en  = dec.errcnt_wr;
   assign errcnt_acc_en = dec.restricted_acc;
   assign timer_acc_en  = dec.restricted_acc;
   assign mbuf_acc_en   = dec.restricted_acc;
endmodule

// File: rtl/can_mode_seq_chk.sv
module can_mode_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic halt_req,
   input logic dbg_halt,
   input logic freeze_en,
   input logic off_req,
   input logic stop_req,
   input logic engine_busy,
   input logic bit_tick,
   input logic rx_bit,
   input logic freeze_ack,
   input logic sleep_ack,
   input logic not_ready
);
   assert_ack_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(freeze_ack && sleep_ack));

   assert_ack_not_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze_ack || sleep_ack) |-> not_ready);

   assert_freeze_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(freeze_ack) |-> $past(freeze_en && (halt_req || dbg_halt) && !off_req && !stop_req));

   assert_freeze_not_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(freeze_ack) |-> $past(!engine_busy));

   assert_sleep_requested_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep_ack) |-> $past(off_req));

   assert_ready_after_recessive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(not_ready) |-> $past(bit_tick && rx_bit, 2));
endmodule

bind can_mode_seq can_mode_seq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .halt_req    (halt_req),
   .dbg_halt    (dbg_halt),
   .freeze_en   (freeze_en),
   .off_req     (off_req),
   .stop_req    (stop_req),
   .engine_busy (engine_busy),
   .bit_tick    (bit_tick),
   .rx_bit      (rx_bit),
   .freeze_ack  (freeze_ack),
   .sleep_ack   (sleep_ack),
   .not_ready   (not_ready)
);

// File: tb/can_mode_seq_tb.sv
`timescale 1ns/1ps
module can_mode_seq_tb_top;
   localparam int RB = 11;

   // order: freeze_ack sleep_ack not_ready presc_run pe_clk bm_clk rx_ign tx_rec ecr_wr ecr_acc tmr_acc mb_acc
   localparam logic [11:0] V_RUN = 12'b000111000111;
   localparam logic [11:0] V_RSY = 12'b001111000111;
   localparam logic [11:0] V_FRZ = 12'b101011111111;
   localparam logic [11:0] V_OFF = 12'b011000110000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic halt_req = 0, dbg_halt = 0, freeze_en = 0, off_req = 0, stop_req = 0;
   logic pe_idle = 0, pe_intermission = 0, pe_err_passive = 0, pe_bus_off = 0;
   logic [1:0] ifs_bit_idx = 2'd0;
   logic bit_tick = 0, rx_bit = 1, engine_busy = 0;
   logic freeze_ack, sleep_ack, not_ready, presc_run, pe_clk_en, bm_clk_en;
   logic rx_ignore, tx_force_rec, errcnt_wr_en, errcnt_acc_en, timer_acc_en, mbuf_acc_en;

   always #2.5 clk = ~clk;

   can_mode_seq dut_i (
      .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .dbg_halt(dbg_halt),
      .freeze_en(freeze_en), .off_req(off_req), .stop_req(stop_req),
      .pe_idle(pe_idle), .pe_intermission(pe_intermission),
      .pe_err_passive(pe_err_passive), .pe_bus_off(pe_bus_off),
      .ifs_bit_idx(ifs_bit_idx), .bit_tick(bit_tick), .rx_bit(rx_bit),
      .engine_busy(engine_busy), .freeze_ack(freeze_ack), .sleep_ack(sleep_ack),
      .not_ready(not_ready), .presc_run(presc_run), .pe_clk_en(pe_clk_en),
      .bm_clk_en(bm_clk_en), .rx_ignore(rx_ignore), .tx_force_rec(tx_force_rec),
      .errcnt_wr_en(errcnt_wr_en), .errcnt_acc_en(errcnt_acc_en),
      .timer_acc_en(timer_acc_en), .mbuf_acc_en(mbuf_acc_en)
   );

   wire [11:0] obs = {freeze_ack, sleep_ack, not_ready, presc_run, pe_clk_en, bm_clk_en,
                      rx_ignore, tx_force_rec, errcnt_wr_en, errcnt_acc_en,
                      timer_acc_en, mbuf_acc_en};

   typedef struct {
      string       tag;
      logic [11:0] exp;
   } sb_item_t;

   sb_item_t sbq[$];
   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   task automatic expect_vec(input string tag, input logic [11:0] v);
      sb_item_t it;
      it.tag = tag;
      it.exp = v;
      sbq.push_back(it);
   endtask

   // monitor: compares after the driver's negedge pushes settle
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (sbq.size() > 0) begin
            sb_item_t it;
            it = sbq.pop_front();
            checks++;
            if (obs !== it.exp) begin
               fails++;
               $display("FAIL %s: got %b expected %b", it.tag, obs, it.exp);
            end
         end
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tick(input logic r);
      bit_tick = 1'b1;
      rx_bit   = r;
      @(negedge clk);
      bit_tick = 1'b0;
      rx_bit   = 1'b1;
   endtask

   task automatic resync_to_run(input string tag);
      repeat (RB) tick(1'b1);
      cyc(1);
      expect_vec(tag, V_RUN);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      cyc(3);
      expect_vec("R1 reset held", V_RSY);
      rst_n = 1'b1;
      cyc(1);
      expect_vec("R1 after release", V_RSY);

      // R6 resync length and restart on dominant
      repeat (RB - 1) tick(1'b1);
      expect_vec("R6 one short", V_RSY);
      tick(1'b0);
      repeat (RB - 1) tick(1'b1);
      expect_vec("R6 restarted count", V_RSY);
      tick(1'b1);
      expect_vec("R6 edge before release", V_RSY);
      cyc(1);
      expect_vec("R6 released", V_RUN);

      // R2 request qualification
      halt_req = 1; pe_idle = 1;
      cyc(3);
      expect_vec("R2 freeze_en low", V_RUN);
      freeze_en = 1; stop_req = 1;
      cyc(3);
      expect_vec("R2 stop active", V_RUN);

      // R3 deferred entry, remembered safe point
      stop_req = 0; pe_idle = 0;
      cyc(3);
      expect_vec("R3 waiting in traffic", V_RUN);
      pe_intermission = 1; engine_busy = 1;
      cyc(1);
      pe_intermission = 0;
      cyc(2);
      expect_vec("R3 waiting busy", V_RUN);
      engine_busy = 0;
      cyc(1);
      expect_vec("R4 frozen", V_FRZ);

      // R5 exit by halt release
      halt_req = 0;
      cyc(1);
      expect_vec("R5 left freeze", V_RSY);
      resync_to_run("R6 after freeze");

      // R2 debugger path, R5 exit by freeze_en
      dbg_halt = 1; pe_err_passive = 1;
      cyc(2);
      expect_vec("R2 debugger freeze", V_FRZ);
      pe_err_passive = 0; freeze_en = 0;
      cyc(1);
      expect_vec("R5 freeze_en cleared", V_RSY);
      freeze_en = 1; pe_idle = 1;
      cyc(2);
      expect_vec("R3 freeze from resync", V_FRZ);

      // R7 off while frozen
      off_req = 1;
      cyc(1);
      expect_vec("R7 off from frozen", V_OFF);
      dbg_halt = 0; pe_idle = 0;
      cyc(2);
      expect_vec("R9 off holds", V_OFF);
      off_req = 0;
      cyc(1);
      expect_vec("R10 off released", V_RSY);
      resync_to_run("R6 after off");

      // R11 withdrawn freeze
      halt_req = 1;
      cyc(2);
      halt_req = 0;
      cyc(2);
      expect_vec("R11 freeze withdrawn", V_RUN);
      pe_idle = 1;
      cyc(2);
      expect_vec("R11 no late freeze", V_RUN);
      pe_idle = 0;

      // R11 withdrawn off
      off_req = 1;
      cyc(2);
      off_req = 0;
      cyc(2);
      expect_vec("R11 off withdrawn", V_RUN);

      // R8 off during traffic at intermission
      off_req = 1;
      cyc(2);
      expect_vec("R8 waiting traffic", V_RUN);
      pe_intermission = 1; ifs_bit_idx = 2'd2;
      tick(1'b1);
      cyc(1);
      expect_vec("R8 second bit ignored", V_RUN);
      ifs_bit_idx = 2'd3;
      tick(1'b0);
      cyc(1);
      expect_vec("R8 dominant third bit", V_RUN);
      engine_busy = 1;
      tick(1'b1);
      pe_intermission = 0; ifs_bit_idx = 2'd0;
      cyc(1);
      expect_vec("R8 point seen busy", V_RUN);
      engine_busy = 0;
      cyc(1);
      expect_vec("R9 off entered", V_OFF);
      off_req = 0;
      cyc(1);
      expect_vec("R10 resync after off", V_RSY);
      resync_to_run("R6 third resync");

      // R8 off at bus-off
      off_req = 1; pe_bus_off = 1;
      cyc(2);
      expect_vec("R8 bus-off entry", V_OFF);
      off_req = 0; pe_bus_off = 0;
      cyc(1);
      expect_vec("R10 final release", V_RSY);

      cyc(2);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule